// File: doc/BRIEF.md
# Rate-Guaranteed Round-Robin Cell Bus Arbiter

This block decides which attached device may place a cell on a shared cell bus in each cell slot. The devices are split into two halves that never compete with each other. In every slot, each half can award at most one grant. A slot runs as a short sequence. First the slot strobe arrives, and the request lines of all devices are sampled as the poll and request step. Then a single-cycle grant pulse appears on the following clock.

Each device carries a programmable rate, counted in units per slot. A half has a capacity of 16 units per slot, which is four buses at four units each. A signed credit counter per device gains the device's rate on every slot and loses the slot cost whenever the device is granted. A device whose credit is positive is behind its guarantee and wins over every requester that is not behind. When no requester is behind, the highest credit wins, so slots left over drift towards the larger rates in proportion. Ties are resolved in round-robin order from a per-half pointer.

Rates are written through a simple write port. A write is refused when it would push the sum of rates in that half above the capacity.

Top module: `cellbus_rate_arb`

## Requirements
- R1: While reset is high and after it is released, grants are zero, all rates and credits are zero, and both round-robin pointers point at the first device of their half.
- R2: A grant appears exactly in the cycle after a clock edge at which `slot_i` was high, lasts one cycle, and is one-hot or zero within each half. No grant follows an edge without the slot strobe.
- R3: If no device of a half requests at the slot edge, that half grants nothing. If at least one requests, exactly one requester of that half is granted.
- R4: Devices 0 to N/2-1 form the lower half and the rest form the upper half. Each half arbitrates and keeps credits on its own, so up to two grants may be issued per slot.
- R5: At every slot edge each device's credit becomes credit + rate, minus 16 if it is the device granted at that edge, clamped to the range [-48, +48].
- R6: A requester with credit > 0 (behind) always wins over requesters with credit <= 0.
- R7: Among requesters that are equally ranked, the first one found scanning upward (with wrap) from the pointer wins. After a grant, the pointer of that half moves to the device after the winner.
- R8: When no requester of a half is behind, the requester with the highest credit wins, which shares excess slots in proportion to the rates.
- R9: A write with `wr_en_i` high stores `wr_rate_i` for device `wr_idx_i` at that clock edge. The credit update at that same edge still uses the old rate. The write is ignored if the new rate plus the rates of the other devices of that half exceeds 16.
- R10: Under full load, with rates summing to 16 in a half, each device's share of grants over a long run matches rate/16 within 1 percent of the slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_i | input | 1 | Cell-slot strobe; requests are sampled on this edge |
| req_i | input | N_DEV | Request line per device |
| wr_en_i | input | 1 | Rate write enable |
| wr_idx_i | input | clog2(N_DEV) | Device whose rate is written |
| wr_rate_i | input | RATE_W | New rate in units per slot |
| grant_o | output | N_DEV | Grant pulse, one-hot or zero per half |

## Verification
The state that is hardest to reach is a half in which some requesters are behind while others sit at the credit clamps. In that state the behind-first rule, the highest-credit rule and the round-robin tie-break all matter in the same slot. The bench gets there in two steps. It first lets chosen devices idle for many slots with nonzero rates until they pin at the upper clamp, while other devices are granted into the lower clamp. It then applies pseudo-random request patterns with irregular slot gaps. A behavioural reference model follows the credits and pointers and predicts the grant vector on every clock.

// File: rtl/cba_pkg.sv
package cba_pkg;

    localparam int GROUPS = 2;

    // Clamp an integer into [lo, hi].
    function automatic int sat_int(input int v, input int lo, input int hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    // Result of one half's selection scan.
    typedef struct packed {
        logic       found;
        logic [7:0] idx;
    } pick_t;

endpackage

// File: rtl/cba_rate_table.sv
module cba_rate_table #(
    parameter int N_DEV     = 8,
    parameter int RATE_W    = 5,
    parameter int SLOT_COST = 16,
    localparam int IDX_W    = $clog2(N_DEV),
    localparam int GRP_N    = N_DEV / cba_pkg::GROUPS
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en_i,
    input  logic [IDX_W-1:0]               wr_idx_i,
    input  logic [RATE_W-1:0]              wr_rate_i,
    output logic [N_DEV-1:0][RATE_W-1:0]   rate_o
);
    logic [N_DEV-1:0][RATE_W-1:0] rate_q;
    int   new_sum;
    logic accept;

    // Admission: the sum over the written device's half, with the new value in place.
    always_comb begin
        new_sum = int'(wr_rate_i);
        for (int i = 0; i < N_DEV; i++) begin
            if ((i / GRP_N) == (int'(wr_idx_i) / GRP_N) && i != int'(wr_idx_i))
                new_sum += int'(rate_q[i]);
        end
        accept = wr_en_i && (new_sum <= SLOT_COST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= '0;
        end else if (accept) begin
            rate_q[wr_idx_i] <= wr_rate_i;
        end
    end

    assign rate_o = rate_q;

    int sum_lo, sum_hi;
    always_comb begin
        sum_lo = 0;
        sum_hi = 0;
        for (int i = 0; i < N_DEV; i++) begin
            if (i < GRP_N) sum_lo += int'(rate_q[i]);
            else           sum_hi += int'(rate_q[i]);
        end
    end

    // R9
    rate_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (sum_lo <= SLOT_COST) && (sum_hi <= SLOT_COST));

    // R9
    rate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> $stable(rate_q));

endmodule

// File: rtl/cba_group_sched.sv
module cba_group_sched #(
    parameter int GRP_N     = 4,
    parameter int RATE_W    = 5,
    parameter int CRED_W    = 8,
    parameter int CRED_HI   = 48,
    parameter int CRED_LO   = -48,
    parameter int SLOT_COST = 16,
    localparam int IDX_W    = $clog2(GRP_N),
    localparam int KEY_W    = CRED_W + 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           slot_i,
    input  logic [GRP_N-1:0]               req_i,
    input  logic [GRP_N-1:0][RATE_W-1:0]   rate_i,
    output logic [GRP_N-1:0]               grant_o
);
    import cba_pkg::*;

    logic signed [CRED_W-1:0] credit_q [GRP_N];
    logic signed [CRED_W-1:0] credit_d [GRP_N];
    logic [IDX_W-1:0]         ptr_q;
    pick_t                    pick;
    logic [GRP_N-1:0]         win_vec;
    logic [GRP_N-1:0]         behind_req;

    // Scan from the pointer upward. Behind requesters all share the top key,
    // so the earliest one in scan order wins among them.
    always_comb begin
        logic [IDX_W-1:0]        cand;
        logic signed [KEY_W-1:0] key;
        logic signed [KEY_W-1:0] best_key;
        pick     = '0;
        best_key = '0;
        for (int k = 0; k < GRP_N; k++) begin
            cand = ptr_q + IDX_W'(k);
            key  = (credit_q[cand] > 0) ? KEY_W'(CRED_HI + 1) : KEY_W'(credit_q[cand]);
            if (req_i[cand] && (!pick.found || key > best_key)) begin
                pick.found = 1'b1;
                pick.idx   = 8'(cand);
                best_key   = key;
            end
        end
        win_vec = '0;
        win_vec[pick.idx[IDX_W-1:0]] = pick.found && slot_i;
    end

    always_comb begin
        for (int i = 0; i < GRP_N; i++) begin
            credit_d[i] = CRED_W'(sat_int(int'(credit_q[i]) + int'(rate_i[i])
                                          - (win_vec[i] ? SLOT_COST : 0),
                                          CRED_LO, CRED_HI));
            behind_req[i] = req_i[i] && (credit_q[i] > 0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_o <= '0;
            ptr_q   <= '0;
            for (int i = 0; i < GRP_N; i++) credit_q[i] <= '0;
        end else begin
            grant_o <= win_vec;
            if (slot_i) begin
                for (int i = 0; i < GRP_N; i++) credit_q[i] <= credit_d[i];
                if (pick.found) ptr_q <= pick.idx[IDX_W-1:0] + 1'b1;
            end
        end
    end

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    // R2
    no_slot_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
        !slot_i |=> (grant_o == '0));

    // R3
    idle_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_i && req_i == '0) |=> (grant_o == '0));

    // R3
    busy_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_i && req_i != '0) |=> ((grant_o & $past(req_i)) != '0));

    // R6
    behind_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_i && behind_req != '0) |=> ((grant_o & $past(behind_req)) != '0));

    for (genvar g = 0; g < GRP_N; g++) begin : g_rng
        // R5
        credit_range_chk: assert property (@(posedge clk) disable iff (rst)
            (int'(credit_q[g]) <= CRED_HI) && (int'(credit_q[g]) >= CRED_LO));
    end

endmodule

// File: rtl/cellbus_rate_arb.sv
module cellbus_rate_arb #(
    parameter int N_DEV     = 8,
    parameter int RATE_W    = 5,
    parameter int CRED_W    = 8,
    parameter int CRED_HI   = 48,
    parameter int CRED_LO   = -48,
    parameter int SLOT_COST = 16,
    localparam int IDX_W    = $clog2(N_DEV),
    localparam int GRP_N    = N_DEV / cba_pkg::GROUPS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 slot_i,
    input  logic [N_DEV-1:0]     req_i,
    input  logic                 wr_en_i,
    input  logic [IDX_W-1:0]     wr_idx_i,
    input  logic [RATE_W-1:0]    wr_rate_i,
    output logic [N_DEV-1:0]     grant_o
);
    logic [N_DEV-1:0][RATE_W-1:0] rate_w;

    cba_rate_table #(
        .N_DEV(N_DEV), .RATE_W(RATE_W), .SLOT_COST(SLOT_COST)
    ) u_rates (
        .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
        .wr_rate_i(wr_rate_i), .rate_o(rate_w)
    );

    for (genvar g = 0; g < cba_pkg::GROUPS; g++) begin : g_half
        cba_group_sched #(
            .GRP_N(GRP_N), .RATE_W(RATE_W), .CRED_W(CRED_W),
            .CRED_HI(CRED_HI), .CRED_LO(CRED_LO), .SLOT_COST(SLOT_COST)
        ) u_sched (
            .clk(clk), .rst(rst), .slot_i(slot_i),
            .req_i(req_i[g*GRP_N +: GRP_N]),
            .rate_i(rate_w[g*GRP_N +: GRP_N]),
            .grant_o(grant_o[g*GRP_N +: GRP_N])
        );
    end

    // R4
    per_half_limit_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(grant_o) <= cba_pkg::GROUPS);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (grant_o == '0));

endmodule

// File: tb/cellbus_rate_arb_bench.sv
module cellbus_rate_arb_bench;
    localparam int N = 8;
    localparam int H = 4;
    localparam int COST = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic slot_i = 1'b0;
    logic [N-1:0] req_i = '0;
    logic wr_en_i = 1'b0;
    logic [2:0] wr_idx_i = '0;
    logic [4:0] wr_rate_i = '0;
    logic [N-1:0] grant_o;

    cellbus_rate_arb u_cellbus_rate_arb (
        .clk(clk), .rst(rst), .slot_i(slot_i), .req_i(req_i),
        .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_rate_i(wr_rate_i),
        .grant_o(grant_o)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int m_rate[N];
    int m_cred[N];
    int m_ptr[2];
    int gcnt[N];
    logic [15:0] lfsr = 16'hACE1;

    function automatic int clampi(int v);
        if (v > 48) return 48;
        if (v < -48) return -48;
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive, predict with the model, compare after the edge.
    task automatic step(input logic [N-1:0] req, input logic slot, input logic we,
                        input int widx, input int wrate, input string tag);
        logic [N-1:0] expv;
        int sum;
        @(negedge clk);
        req_i = req; slot_i = slot; wr_en_i = we;
        wr_idx_i = 3'(widx); wr_rate_i = 5'(wrate);
        expv = '0;
        if (slot) begin
            for (int g = 0; g < 2; g++) begin
                int best, bk;
                best = -1; bk = 0;
                for (int k = 0; k < H; k++) begin
                    int idx, key;
                    idx = g*H + (m_ptr[g] + k) % H;
                    if (req[idx]) begin
                        key = (m_cred[idx] > 0) ? 1000 : m_cred[idx];
                        if (best < 0 || key > bk) begin best = idx; bk = key; end
                    end
                end
                if (best >= 0) begin
                    expv[best] = 1'b1;
                    m_ptr[g] = (best - g*H + 1) % H;
                end
            end
            for (int i = 0; i < N; i++)
                m_cred[i] = clampi(m_cred[i] + m_rate[i] - (expv[i] ? COST : 0));
        end
        if (we) begin
            sum = wrate;
            for (int i = 0; i < N; i++)
                if (i / H == widx / H && i != widx) sum += m_rate[i];
            if (sum <= COST) m_rate[widx] = wrate;
        end
        @(posedge clk);
        #1;
        check(grant_o === expv, tag, int'(grant_o), int'(expv));
        for (int i = 0; i < N; i++) if (grant_o[i]) gcnt[i]++;
    endtask

    task automatic set_rate(input int idx, input int r, input string tag);
        step('0, 1'b0, 1'b1, idx, r, tag);
    endtask

    task automatic clear_counts();
        for (int i = 0; i < N; i++) gcnt[i] = 0;
    endtask

    function automatic logic [15:0] lfsr_next(logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_rate[i] = 0; m_cred[i] = 0; end
        m_ptr[0] = 0; m_ptr[1] = 0;
        clear_counts();
        repeat (3) @(posedge clk);
        #1;
        check(grant_o === '0, "R1 grant during reset", int'(grant_o), 0);
        @(negedge clk); rst = 1'b0;

        // R1: zero rates and pointers at first device -> device 0 and 4 first
        step('1, 1'b1, 1'b0, 0, 0, "R1");
        // R2: no slot strobe means no grant
        for (int c = 0; c < 6; c++) step('1, 1'b0, 1'b0, 0, 0, "R2");
        // R7: rate zero everywhere, equal ranks
        for (int c = 0; c < 16; c++) step('1, 1'b1, 1'b0, 0, 0, "R7");
        // R3: no requests in either half
        for (int c = 0; c < 6; c++) step('0, 1'b1, 1'b0, 0, 0, "R3");
        // R4: only the upper half requests
        for (int c = 0; c < 8; c++) step(8'hF0, 1'b1, 1'b0, 0, 0, "R4");

        // R9: program the rates
        set_rate(0, 8, "R9"); set_rate(1, 4, "R9"); set_rate(2, 2, "R9"); set_rate(3, 2, "R9");
        for (int i = 4; i < N; i++) set_rate(i, 4, "R9");

        // R10: full load, long run
        clear_counts();
        for (int c = 0; c < 1600; c++) step('1, 1'b1, 1'b0, 0, 0, "R10");
        check(gcnt[0] >= 784 && gcnt[0] <= 816, "R10 dev0 share", gcnt[0], 800);
        check(gcnt[1] >= 384 && gcnt[1] <= 416, "R10 dev1 share", gcnt[1], 400);
        check(gcnt[2] >= 184 && gcnt[2] <= 216, "R10 dev2 share", gcnt[2], 200);
        check(gcnt[5] >= 384 && gcnt[5] <= 416, "R10 dev5 share", gcnt[5], 400);

        // R9: over-capacity write to the upper half is refused
        set_rate(4, 9, "R9");
        clear_counts();
        for (int c = 0; c < 400; c++) step(8'hF0, 1'b1, 1'b0, 0, 0, "R9");
        check(gcnt[4] >= 96 && gcnt[4] <= 104, "R9 rejected write unchanged share", gcnt[4], 100);
        check(gcnt[7] >= 96 && gcnt[7] <= 104, "R9 dev7 share", gcnt[7], 100);

        // R5: idle devices climb to the upper clamp while others are granted
        for (int c = 0; c < 40; c++) step(8'h0C, 1'b1, 1'b0, 0, 0, "R5");
        // R6: clamped idle devices come back behind and must win first
        for (int c = 0; c < 40; c++) step('1, 1'b1, 1'b0, 0, 0, "R6");

        // R8: lower half at rate sum below capacity so excess is shared
        set_rate(0, 3, "R8"); set_rate(1, 1, "R8");
        for (int c = 0; c < 200; c++) step(8'h0F, 1'b1, 1'b0, 0, 0, "R8");

        // R7: pseudo-random requests with irregular slots
        for (int c = 0; c < 1500; c++) begin
            lfsr = lfsr_next(lfsr);
            step(lfsr[7:0], lfsr[9] | lfsr[11], 1'b0, 0, 0, "R7");
        end
        // R6: random again after idle build-up
        for (int c = 0; c < 30; c++) step(8'h11, 1'b1, 1'b0, 0, 0, "R6");
        for (int c = 0; c < 600; c++) begin
            lfsr = lfsr_next(lfsr);
            step(lfsr[15:8], lfsr[2], 1'b0, 0, 0, "R6");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule